// File: doc/BRIEF.md
# Line Transceiver Control and Protection

This block makes the digital decisions for a differential bus transceiver that can be wired for half- or full-duplex use. It takes the driver enable, the active-low receiver enable, the transmit bit, one power-good flag for each side of the isolation barrier, and the die temperature in degrees Celsius. From these it produces the two complementary line drive values and one shared drive enable. When a driver output is not enabled, the design drives both line values to 0.

The receive path takes a signed differential input code in millivolts and an open-input flag. It resolves the received bit with fail-safe thresholds, so an idle line at 0 mV reads as high. Between the two thresholds lies an uncertain band. In that band the bit keeps its last resolved value, and a flag reports that the value is not guaranteed.

A registered thermal guard trips at a high temperature and clears only at a lower one. While it is tripped, the driver is disabled. All pins are plain level signals. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure.

Top module: `xc_line_ctl`

## Requirements
- R1: While `line_oe` is 1, `line_p` equals `tx_bit` and `line_n` is its complement.
- R2: `line_oe` is 0 whenever `drv_en` is 0 or `bus_pwr_ok` is 0. Whenever `line_oe` is 0, both `line_p` and `line_n` are 0.
- R3: `line_oe` is 0 whenever `logic_pwr_ok` is 0, and is 1 exactly when `drv_en`, both power flags are 1 and `therm_trip` is 0.
- R4: `rx_oe` is the inverse of `rcv_en_n`. While `rcv_en_n` is 1, `rx_uncertain` is 0.
- R5: With both supplies good and `inputs_open` at 0, `rx_bit` is 1 when `diff_mv` (two's complement, millivolts) is greater than -30, and 0 when it is less than -200.
- R6: Forced receive states, in priority order: `logic_pwr_ok`=0 gives `rx_bit`=0; otherwise `bus_pwr_ok`=0 or `inputs_open`=1 gives `rx_bit`=1.
- R7: `therm_trip` sets on the clock after a cycle where it is 0 and `die_temp_c` is at least 150. It clears on the clock after a cycle where it is 1 and `die_temp_c` is at most 140. Otherwise it keeps its value.
- R8: With both supplies good and no open input, `diff_mv` in the range -200..-30 (inclusive) makes `rx_bit` equal its value in the previous cycle. It also sets `rx_uncertain` to 1 when the receiver is enabled. In every other case `rx_uncertain` is 0.
- R9: The thermal state is registered. The cycle in which the temperature first crosses the trip level still drives the line, and `line_oe` falls in the following cycle, staying 0 while `therm_trip` is 1.
- R10: Reset clears `therm_trip` and sets the held receive value to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drv_en | input | 1 | Driver enable, active high |
| rcv_en_n | input | 1 | Receiver enable, active low |
| tx_bit | input | 1 | Bit to transmit |
| logic_pwr_ok | input | 1 | Logic-side supply good |
| bus_pwr_ok | input | 1 | Bus-side supply good |
| diff_mv | input | MV_W (12) | Signed differential input voltage, mV |
| inputs_open | input | 1 | Receiver inputs detected open |
| die_temp_c | input | TEMP_W (10) | Signed die temperature, degrees C |
| line_p | output | 1 | Non-inverting line drive value |
| line_n | output | 1 | Inverting line drive value |
| line_oe | output | 1 | Line drive enable |
| rx_bit | output | 1 | Received bit |
| rx_oe | output | 1 | Received bit output enable |
| rx_uncertain | output | 1 | Received bit lies in the uncertain band |
| therm_trip | output | 1 | Thermal shutdown active |

## Verification
The driver gating is tried with all sixteen combinations of driver enable, both power flags and the transmit bit. This separates the effect of each gating term from that of the data bit.

The differential input is swept one millivolt at a time downward from +40 to -260 and then back up. The downward pass shows that the band holds a high value and the upward pass shows that it holds a low one, so both thresholds and their inclusive edges are pinned.

The forced states are stacked against a strongly negative input, which shows their priority. A temperature ramp up to 160 and back down to 120 shows the trip edge, the one-cycle lag, and that the band from 141 to 149 keeps the tripped state.

// File: rtl/xc_line_pkg.sv
package xc_line_pkg;
  typedef enum logic [1:0] {
    ZONE_HIGH = 2'd0,
    ZONE_LOW  = 2'd1,
    ZONE_BAND = 2'd2
  } rx_zone_e;
endpackage

// File: rtl/xc_therm_guard.sv
module xc_therm_guard #(
  parameter int TEMP_W  = 10,
  parameter int TRIP_C  = 150,
  parameter int CLEAR_C = 140
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [TEMP_W-1:0] temp_c,
  output logic                     trip
);
  localparam logic signed [TEMP_W-1:0] TRIP_Q  = TEMP_W'(TRIP_C);
  localparam logic signed [TEMP_W-1:0] CLEAR_Q = TEMP_W'(CLEAR_C);

  always_ff @(posedge clk) begin
    if (!rst_n) trip <= 1'b0;
    else if (!trip && temp_c >= TRIP_Q) trip <= 1'b1;
    else if (trip && temp_c <= CLEAR_Q) trip <= 1'b0;
  end

  assert_trip_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!trip && temp_c >= TRIP_Q) |=> trip);
  assert_trip_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && temp_c <= CLEAR_Q) |=> !trip);
  assert_trip_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && temp_c > CLEAR_Q) |=> trip);
  assert_no_early_trip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!trip && temp_c < TRIP_Q) |=> !trip);
endmodule

// File: rtl/xc_drive_gate.sv
module xc_drive_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic drv_en,
  input  logic tx_bit,
  input  logic logic_ok,
  input  logic bus_ok,
  input  logic trip,
  output logic line_p,
  output logic line_n,
  output logic line_oe
);
  always_comb begin
    line_oe = drv_en & logic_ok & bus_ok & ~trip;
    line_p  = line_oe & tx_bit;
    line_n  = line_oe & ~tx_bit;
  end

  assert_drive_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe |-> (line_p == tx_bit && line_n != line_p));
  assert_drive_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_en || !bus_ok) |-> (!line_oe && !line_p && !line_n));
  assert_logic_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !logic_ok |-> !line_oe);
  assert_trip_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trip |-> !line_oe);
endmodule

// File: rtl/xc_rx_decide.sv
module xc_rx_decide
  import xc_line_pkg::*;
#(
  parameter int MV_W     = 12,
  parameter int FS_HI_MV = -30,
  parameter int FS_LO_MV = -200
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rcv_en_n,
  input  logic                   logic_ok,
  input  logic                   bus_ok,
  input  logic                   inputs_open,
  input  logic signed [MV_W-1:0] diff_mv,
  output logic                   rx_bit,
  output logic                   rx_oe,
  output logic                   rx_uncertain
);
  localparam logic signed [MV_W-1:0] HI_Q = MV_W'(FS_HI_MV);
  localparam logic signed [MV_W-1:0] LO_Q = MV_W'(FS_LO_MV);

  rx_zone_e zone;
  logic     held;
  logic     rx_val;
  logic     in_band;

  always_comb begin
    if (diff_mv > HI_Q)      zone = ZONE_HIGH;
    else if (diff_mv < LO_Q) zone = ZONE_LOW;
    else                     zone = ZONE_BAND;
  end

  always_comb begin
    rx_val  = held;
    in_band = 1'b0;
    if (!logic_ok)                  rx_val = 1'b0;
    else if (!bus_ok || inputs_open) rx_val = 1'b1;
    else begin
      case (zone)
        ZONE_HIGH: rx_val = 1'b1;
        ZONE_LOW:  rx_val = 1'b0;
        default:   in_band = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) held <= 1'b1;
    else        held <= rx_val;
  end

  assign rx_bit       = rx_val;
  assign rx_oe        = ~rcv_en_n;
  assign rx_uncertain = in_band & ~rcv_en_n;

  assert_band_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_uncertain && $past(rst_n)) |-> (rx_bit == $past(rx_bit)));
  assert_fail_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (logic_ok && inputs_open) |-> rx_bit);
  assert_low_thresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (logic_ok && bus_ok && !inputs_open && diff_mv < LO_Q) |-> !rx_bit);
  assert_rx_disable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rcv_en_n |-> (!rx_oe && !rx_uncertain));
endmodule

// File: rtl/xc_line_ctl.sv
module xc_line_ctl #(
  parameter int MV_W    = 12,
  parameter int TEMP_W  = 10,
  parameter int TRIP_C  = 150,
  parameter int CLEAR_C = 140
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     drv_en,
  input  logic                     rcv_en_n,
  input  logic                     tx_bit,
  input  logic                     logic_pwr_ok,
  input  logic                     bus_pwr_ok,
  input  logic signed [MV_W-1:0]   diff_mv,
  input  logic                     inputs_open,
  input  logic signed [TEMP_W-1:0] die_temp_c,
  output logic                     line_p,
  output logic                     line_n,
  output logic                     line_oe,
  output logic                     rx_bit,
  output logic                     rx_oe,
  output logic                     rx_uncertain,
  output logic                     therm_trip
);
  logic trip_q;

  xc_therm_guard #(.TEMP_W(TEMP_W), .TRIP_C(TRIP_C), .CLEAR_C(CLEAR_C)) u_therm (
    .clk(clk), .rst_n(rst_n), .temp_c(die_temp_c), .trip(trip_q)
  );

  xc_drive_gate u_drive (
    .clk(clk), .rst_n(rst_n), .drv_en(drv_en), .tx_bit(tx_bit),
    .logic_ok(logic_pwr_ok), .bus_ok(bus_pwr_ok), .trip(trip_q),
    .line_p(line_p), .line_n(line_n), .line_oe(line_oe)
  );

  xc_rx_decide #(.MV_W(MV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rcv_en_n(rcv_en_n), .logic_ok(logic_pwr_ok),
    .bus_ok(bus_pwr_ok), .inputs_open(inputs_open), .diff_mv(diff_mv),
    .rx_bit(rx_bit), .rx_oe(rx_oe), .rx_uncertain(rx_uncertain)
  );

  assign therm_trip = trip_q;
endmodule

// File: tb/xc_line_ctl_bench.sv
module xc_line_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic de = 1'b0, ren = 1'b0, tx = 1'b0, lo = 1'b1, bo = 1'b1, op = 1'b0;
  logic signed [11:0] diff = '0;
  logic signed [9:0]  temp = 10'sd25;
  logic lp, ln, loe, rxb, rxoe, unc, trip;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic m_trip = 1'b0;
  logic m_held = 1'b1;

  always #2.5 clk = ~clk;

  xc_line_ctl u_xc_line_ctl (
    .clk(clk), .rst_n(rst_n), .drv_en(de), .rcv_en_n(ren), .tx_bit(tx),
    .logic_pwr_ok(lo), .bus_pwr_ok(bo), .diff_mv(diff), .inputs_open(op),
    .die_temp_c(temp), .line_p(lp), .line_n(ln), .line_oe(loe),
    .rx_bit(rxb), .rx_oe(rxoe), .rx_uncertain(unc), .therm_trip(trip)
  );

  task automatic chk(input string ph, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0b exp=%0b (diff=%0d temp=%0d)", ph, what, act, exp, diff, temp);
    end
  endtask

  // Caller sets inputs just after a falling edge; compare, then advance the model one clock.
  task automatic step(input string ph);
    logic e_oe, e_rx, band;
    int d;
    #1;
    d = diff;
    e_oe = de && lo && bo && !m_trip;
    band = 1'b0;
    if (!lo) e_rx = 1'b0;
    else if (!bo || op) e_rx = 1'b1;
    else if (d > -30) e_rx = 1'b1;
    else if (d < -200) e_rx = 1'b0;
    else begin e_rx = m_held; band = 1'b1; end
    chk(ph, "line_oe", loe, e_oe);
    chk(ph, "line_p", lp, e_oe & tx);
    chk(ph, "line_n", ln, e_oe & ~tx);
    chk(ph, "rx_oe", rxoe, ~ren);
    chk(ph, "rx_bit", rxb, e_rx);
    chk(ph, "rx_uncertain", unc, band & ~ren);
    chk(ph, "therm_trip", trip, m_trip);
    @(posedge clk);
    m_held = e_rx;
    if (!m_trip && temp >= 150) m_trip = 1'b1;
    else if (m_trip && temp <= 140) m_trip = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R10", "therm_trip in reset", trip, 1'b0);
    rst_n = 1'b1;
    // R10: held value starts at 1, visible through the uncertain band
    diff = -12'sd100;
    step("R10");

    // R1, R2, R3: every gating combination
    for (int i = 0; i < 16; i++) begin
      de = i[0]; lo = i[1]; bo = i[2]; tx = i[3];
      step("R1,R2,R3");
    end
    lo = 1'b1; bo = 1'b1; de = 1'b1; tx = 1'b0;

    // R5, R8: full threshold sweep down then up
    diff = 12'sd40;
    step("R5,R8");
    for (int v = 40; v >= -260; v--) begin
      diff = 12'(v);
      step("R5,R8");
    end
    for (int v = -260; v <= 40; v++) begin
      diff = 12'(v);
      step("R5,R8");
    end

    // R4: receiver disabled
    ren = 1'b1;
    diff = 12'sd0;     step("R4");
    diff = -12'sd100;  step("R4");
    diff = -12'sd300;  step("R4");
    ren = 1'b0;

    // R6: forced states and their priority
    diff = -12'sd500; op = 1'b1; step("R6");
    op = 1'b0; bo = 1'b0;        step("R6");
    bo = 1'b1; lo = 1'b0; diff = 12'sd100; step("R6");
    op = 1'b1; bo = 1'b0;        step("R6");
    lo = 1'b1; bo = 1'b1; op = 1'b0;
    diff = 12'sd100; step("R6");

    // R7, R9: temperature ramp up and down
    de = 1'b1; tx = 1'b1;
    for (int t = 100; t <= 160; t++) begin
      temp = 10'(t);
      step("R7,R9");
    end
    for (int t = 160; t >= 120; t--) begin
      temp = 10'(t);
      step("R7,R9");
    end
    temp = 10'sd145; step("R7,R9");
    temp = 10'sd150; step("R7,R9");
    temp = 10'sd149; step("R7,R9");
    temp = 10'sd141; step("R7,R9");
    temp = 10'sd140; step("R7,R9");
    step("R7,R9");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule